// File: doc/BRIEF.md
# Burst Phase-Step Generator

This block produces an endless train of upstream bursts for stressing a burst-mode clock and data recovery receiver. Each burst has three parts, in this order: an alternating training pattern of programmable length, a 32-bit delimiter word and a truncated PRBS-7 payload. An all-zero idle gap of programmable length follows each burst. Every clock cycle covers one line bit. The output is a two-sample word for a downstream serializer that runs at twice the line rate, so the receiver sees each line bit as two equal samples.

Because the output is oversampled, the generator can delay a whole burst by one sample, which is half a unit interval. When shifting is enabled, this delay is switched on and off on alternate bursts. Consecutive bursts then differ by the worst phase step that two different senders can present. All length, delimiter and shift settings are captured once per burst, at the moment the burst starts. The error-insert input acts on payload bits at once, as long as it is held.

Top module: `burst_phase_gen`

## Requirements
- R1: When the burst offset is 0, each line bit appears on `samples_o` as two equal samples in one word. `samples_o[1]` is the sample sent first.
- R2: When the burst offset is 1, the sample stream is delayed by one sample. Each word then carries the second sample of the previous bit in `samples_o[1]` and the first sample of the current bit in `samples_o[0]`.
- R3: The offset is 0 out of reset. At each burst start it is set to the inverse of the previous burst's offset if `cfg_shift_en` is 1, and to 0 otherwise. With shifting enabled from reset, the first burst therefore has offset 1.
- R4: A burst opens with `cfg_pre_len` preamble bits, from 0 to 16383. The preamble is an alternating pattern whose first bit is 1, and a length of 0 omits it.
- R5: The 32 bits of `cfg_delim` follow the preamble, most significant bit first.
- R6: Next come `cfg_pay_len` payload bits, and a length of 0 omits the payload. The payload is generated by x^7+x^6+1. A 7-bit register is seeded to 1111111 in every burst. Each payload bit is register bit 6, after which the register shifts left and takes bit6 XOR bit5 into bit 0.
- R7: After each burst the output is all-zero for max(`cfg_gap_len`,1) bit periods, which is at least two samples.
- R8: Length, delimiter and shift settings are sampled only when a burst starts. Changes made during a burst or its gap take effect at the next burst start.
- R9: While `cfg_err_ins` is 1, every payload bit emitted in that cycle is inverted. It has no effect on the preamble, the delimiter or the gap.
- R10: `samples_o` is zero during reset. The first bit of the first burst appears on the output after the second rising clock edge following reset release. Each later burst starts P+32+L+max(G,1) cycles after the previous one, where P, L and G are that previous burst's preamble, payload and gap settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pre_len | input | 14 | Preamble length in bits |
| cfg_pay_len | input | 16 | Payload length in bits |
| cfg_gap_len | input | 8 | Idle gap length in bit periods (0 behaves as 1) |
| cfg_delim | input | 32 | Delimiter word, sent MSB first |
| cfg_shift_en | input | 1 | Enables alternating half-UI burst offset |
| cfg_err_ins | input | 1 | Inverts payload bits while high |
| samples_o | output | 2 | Two output samples per bit; bit 1 sent first |

## Verification
The bench aims at the places where the half-sample shift and the burst boundaries meet. One is the last payload sample that spills into the gap when a shifted burst ends. A design that zeroed this sample or merged it wrongly would show a one-sample glitch there. Another is the 1-to-0 offset change at the next burst start, where a wrong design would flip an unshifted burst's sample pair. Zero-length preamble and payload, a zero gap setting and an 8192-bit preamble are run as well. Each would show up as a miscounted burst period or a missing delimiter. A payload longer than the PRBS-7 period must wrap seamlessly, and the generator must restart from the seed in every burst. A settings change in the middle of a burst must leave that burst untouched, or every word from the change onward moves.

// File: rtl/burst_phase_gen.sv
module burst_phase_gen #(
  parameter int PRE_W   = 14,
  parameter int PAY_W   = 16,
  parameter int GAP_W   = 8,
  parameter int DELIM_W = 32,
  parameter logic [6:0] SEED = 7'h7F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRE_W-1:0]   cfg_pre_len,
  input  logic [PAY_W-1:0]   cfg_pay_len,
  input  logic [GAP_W-1:0]   cfg_gap_len,
  input  logic [DELIM_W-1:0] cfg_delim,
  input  logic               cfg_shift_en,
  input  logic               cfg_err_ins,
  output logic [1:0]         samples_o
);
  localparam int DI_W  = $clog2(DELIM_W) + 1;
  localparam int M1    = (PRE_W > PAY_W) ? PRE_W : PAY_W;
  localparam int M2    = (M1 > GAP_W) ? M1 : GAP_W;
  localparam int CNT_W = (M2 > DI_W) ? M2 : DI_W;

  typedef enum logic [1:0] {S_GAP = 2'd0, S_PRE = 2'd1, S_DLM = 2'd2, S_PAY = 2'd3} st_t;

  st_t                st;
  logic [CNT_W-1:0]   cnt;
  logic [PRE_W-1:0]   pre_l;
  logic [PAY_W-1:0]   pay_l;
  logic [GAP_W-1:0]   gap_l;
  logic [DELIM_W-1:0] dsh;
  logic [6:0]         lfsr;
  logic               off, prev, bit_c;

  wire [CNT_W-1:0] pre_end = CNT_W'(pre_l) - CNT_W'(1);
  wire [CNT_W-1:0] pay_end = CNT_W'(pay_l) - CNT_W'(1);
  wire [CNT_W-1:0] gap_end = (gap_l == '0) ? '0 : CNT_W'(gap_l) - CNT_W'(1);
  wire [CNT_W-1:0] dlm_end = CNT_W'(DELIM_W - 1);

  always_comb begin
    case (st)
      S_PRE:   bit_c = ~cnt[0];
      S_DLM:   bit_c = dsh[DELIM_W-1];
      S_PAY:   bit_c = lfsr[6] ^ cfg_err_ins;
      default: bit_c = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_GAP;
      cnt       <= '0;
      pre_l     <= '0;
      pay_l     <= '0;
      gap_l     <= '0;
      dsh       <= '0;
      lfsr      <= SEED;
      off       <= 1'b0;
      prev      <= 1'b0;
      samples_o <= 2'b00;
    end else begin
      prev      <= bit_c;
      samples_o <= off ? {prev, bit_c} : {bit_c, bit_c};
      cnt       <= cnt + 1'b1;
      case (st)
        S_GAP: if (cnt == gap_end) begin
          cnt   <= '0;
          pre_l <= cfg_pre_len;
          pay_l <= cfg_pay_len;
          gap_l <= cfg_gap_len;
          dsh   <= cfg_delim;
          lfsr  <= SEED;
          off   <= cfg_shift_en & ~off;
          st    <= (cfg_pre_len != '0) ? S_PRE : S_DLM;
        end
        S_PRE: if (cnt == pre_end) begin
          cnt <= '0;
          st  <= S_DLM;
        end
        S_DLM: begin
          dsh <= {dsh[DELIM_W-2:0], 1'b0};
          if (cnt == dlm_end) begin
            cnt <= '0;
            st  <= (pay_l != '0) ? S_PAY : S_GAP;
          end
        end
        S_PAY: begin
          lfsr <= {lfsr[5:0], lfsr[6] ^ lfsr[5]};
          if (cnt == pay_end) begin
            cnt <= '0;
            st  <= S_GAP;
          end
        end
        default: st <= S_GAP;
      endcase
    end
  end
endmodule

module burst_phase_gen_chk #(
  parameter int PRE_W = 14,
  parameter int PAY_W = 16,
  parameter int GAP_W = 8,
  parameter logic [6:0] SEED = 7'h7F
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       samples_o,
  input logic [1:0]       st,
  input logic             off,
  input logic [6:0]       lfsr,
  input logic [PRE_W-1:0] pre_l,
  input logic [PAY_W-1:0] pay_l,
  input logic [GAP_W-1:0] gap_l
);
  assert_pair_equal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !off |=> (samples_o[1] == samples_o[0]));

  assert_half_ui_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> (samples_o[1] == $past(samples_o[0])));

  assert_offset_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'd0) |=> $stable(off));

  assert_seed_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3 && $past(st) != 2'd3) |-> (lfsr == SEED));

  assert_gap_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && $past(st) == 2'd0) |=> (samples_o == 2'b00));

  assert_cfg_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'd0) |=> ($stable(pre_l) && $stable(pay_l) && $stable(gap_l)));
endmodule

bind burst_phase_gen burst_phase_gen_chk #(
  .PRE_W(PRE_W), .PAY_W(PAY_W), .GAP_W(GAP_W), .SEED(SEED)
) u_chk (
  .clk(clk), .rst_n(rst_n), .samples_o(samples_o), .st(st), .off(off),
  .lfsr(lfsr), .pre_l(pre_l), .pay_l(pay_l), .gap_l(gap_l)
);

// File: tb/test_burst_phase_gen.sv
module test_burst_phase_gen;
  typedef struct packed {
    logic [13:0] pre;
    logic [15:0] pay;
    logic [7:0]  gap;
    logic        sh;
    logic        err;
    logic [31:0] dl;
    logic [15:0] per;
  } cfg_t;

  localparam cfg_t TBL [0:7] = '{
    '{14'd8,    16'd20,  8'd4, 1'b0, 1'b0, 32'hB5C39A17, 16'd64},
    '{14'd8,    16'd20,  8'd4, 1'b1, 1'b0, 32'hB5C39A17, 16'd64},
    '{14'd0,    16'd15,  8'd3, 1'b1, 1'b0, 32'hD00DF00D, 16'd50},
    '{14'd5,    16'd0,   8'd2, 1'b0, 1'b0, 32'h8E2147AC, 16'd39},
    '{14'd12,   16'd30,  8'd0, 1'b1, 1'b0, 32'hC3A55A3C, 16'd75},
    '{14'd6,    16'd127, 8'd2, 1'b0, 1'b1, 32'hF0E1D2C3, 16'd167},
    '{14'd3,    16'd140, 8'd1, 1'b1, 1'b0, 32'h9ABCDEF0, 16'd176},
    '{14'd0,    16'd0,   8'd1, 1'b1, 1'b0, 32'hA5A5C3C3, 16'd33}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [13:0] cfg_pre_len;
  logic [15:0] cfg_pay_len;
  logic [7:0]  cfg_gap_len;
  logic [31:0] cfg_delim;
  logic        cfg_shift_en, cfg_err_ins;
  logic [1:0]  samples_o;

  int checks = 0, fails = 0;
  bit done = 0;
  cfg_t bc [0:3];
  int   bs [0:3];
  logic bo [0:3];

  always #4 clk = ~clk;

  burst_phase_gen i_burst_phase_gen (
    .clk(clk), .rst_n(rst_n), .cfg_pre_len(cfg_pre_len), .cfg_pay_len(cfg_pay_len),
    .cfg_gap_len(cfg_gap_len), .cfg_delim(cfg_delim), .cfg_shift_en(cfg_shift_en),
    .cfg_err_ins(cfg_err_ins), .samples_o(samples_o)
  );

  function automatic logic prbs(int j);
    logic [6:0] l = 7'h7F;
    for (int k = 0; k < j; k++) l = {l[5:0], l[6] ^ l[5]};
    return l[6];
  endfunction

  function automatic logic sample_at(int s);
    for (int n = 0; n < 4; n++) begin
      int o = int'(bo[n]);
      if (s >= 2 * bs[n] + o) begin
        int t = (s - o) / 2 - bs[n];
        int p = int'(bc[n].pre);
        int l = int'(bc[n].pay);
        if (t < p) return (t % 2) == 0;
        if (t < p + 32) return bc[n].dl[31 - (t - p)];
        if (t < p + 32 + l) return prbs(t - p - 32) ^ bc[n].err;
      end
    end
    return 1'b0;
  endfunction

  task automatic apply(cfg_t c);
    cfg_pre_len = c.pre; cfg_pay_len = c.pay; cfg_gap_len = c.gap;
    cfg_delim = c.dl; cfg_shift_en = c.sh; cfg_err_ins = c.err;
  endtask

  task automatic run(cfg_t a, cfg_t b, int chg, string tag);
    logic prv = 1'b0;
    int bad = 0, endc;
    logic [1:0] fa = 2'b00, fe = 2'b00;
    int fc = -1;
    rst_n = 1'b0;
    apply(a);
    repeat (3) @(negedge clk);
    checks++;
    if (samples_o !== 2'b00) begin
      fails++;
      $display("FAIL R10 %s reset output: actual %b expected 00", tag, samples_o);
    end
    bc[0] = a;
    for (int n = 1; n < 4; n++) bc[n] = b;
    bs[0] = 2;
    for (int n = 1; n < 4; n++) bs[n] = bs[n-1] + int'(bc[n-1].per);
    for (int n = 0; n < 4; n++) begin
      bo[n] = bc[n].sh ? ~prv : 1'b0;
      prv = bo[n];
    end
    endc = bs[3] - 1;
    rst_n = 1'b1;
    for (int c = 1; c <= endc; c++) begin
      logic [1:0] e;
      @(posedge clk);
      @(negedge clk);
      if (c == chg) apply(b);
      e = {sample_at(2 * c), sample_at(2 * c + 1)};
      if (samples_o !== e) begin
        if (bad == 0) begin fc = c; fa = samples_o; fe = e; end
        bad++;
      end
    end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL R1-stream R2 R3 %s: %0d words wrong, first at cycle %0d actual %b expected %b",
               tag, bad, fc, fa, fe);
    end
  endtask

  initial begin
    cfg_t lp, ca, cb;
    // R1 R2 R3 R4 R5 R6 R7 R9 R10: table walk
    for (int v = 0; v < 8; v++) run(TBL[v], TBL[v], -1, $sformatf("R4 R5 R6 R7 vector %0d", v));
    // R8: settings changed in the middle of the first burst
    ca = TBL[0]; cb = TBL[2];
    run(ca, cb, 10, "R8 mid-burst change");
    // R4 R10: long preamble
    lp = '{14'd8192, 16'd10, 8'd2, 1'b1, 1'b0, 32'h8421F00F, 16'd8236};
    run(lp, lp, -1, "R4 long preamble");
    // R9: error insert turned on mid-burst is seen at once on payload (burst 1 on)
    ca = TBL[0]; cb = TBL[0]; cb.err = 1'b1;
    run(ca, cb, 70, "R9 error insert");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R10 watchdog expired: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule